// File: doc/BRIEF.md
# Configuration Transaction Controller

The block is a small command engine that sits behind three word registers on a simple register bus. Software places an operand in the data register and then writes a command word to the control register. If the command's launch bit is set, the engine decodes the command in the following cycle. The decoded command names a direction, a controller select, a function, a site, a position and a device index. The engine then reads or writes one of a bank of oscillator-frequency registers, returns a fixed supply-voltage value, or raises a one-cycle shutdown or reboot request.

Every launched command finishes exactly one cycle after the launching write. The result is reported in a two-bit status register: bit 0 means done and bit 1 means error. A command that names a target the engine does not implement is not left pending. It completes with the error bit set and changes no other register. A successful read leaves its result in the data register, and a write takes its operand from that same register.

Top module: `cfg_txn_ctrl`

## Requirements
- R1: A bus write to offset 0xA4 stores the command word with bits 31, 19 and 18 cleared, and reading 0xA4 returns that stored value. The command layout is: launch bit 31, direction bit 30 (1 = write), controller select 29:26, function 25:20, site 17:16, position 15:12, device 11:0.
- R2: Offset 0xA0 is the data register and is readable and writable. Any offset other than 0xA0, 0xA4 and 0xA8 reads as zero and ignores writes.
- R3: A launched command finishes with status 2'b11 and changes neither the data register nor any oscillator register when it is unsupported. Unsupported means any of the following: controller select is not 0, position is not 0, site is greater than 1, or the combination of function, site, device and direction is not one of those listed in R5, R7, R8 and R9.
- R4: The status register resets to 0. The edge that stores a control write with bit 31 set clears the status to 2'b00, and the next edge sets it to 2'b01 on success or 2'b11 on failure.
- R5: Function 1 on site 0 with device 0 to 5 reads the addressed oscillator register into the data register, or writes the data register's value into it. The reset values of the six registers are 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000.
- R6: A function 1 command with a device index of 6 or more sets the error bit and changes no oscillator register.
- R7: A read with function 2 on site 0, device 0 places 3300000 in the data register. Any other function 2 command is unsupported.
- R8: A write with function 8 on site 0, device 0 drives shutdown_req high for exactly the one cycle after completion. Function 9 does the same on reboot_req. Reads of these functions raise no pulse and are unsupported.
- R9: Writes with function 7 or function 11 on site 0, device 0 complete with status 2'b01 and have no other effect.
- R10: A bus write to offset 0xA8 stores only bits 1:0 of the written word into the status register.
- R11: A control write with bit 31 clear stores the command but launches nothing: the status register and the data register stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe for the current cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
The embedded assertions check the following on every cycle:
- Any pending command is done on the next edge.
- An unsupported decode yields status 2'b11 and a supported one yields 2'b01.
- The two request pulses never coincide and only follow a pending command.
- Oscillator entries that are not being written hold their value.

Only the bench scenarios can show the actual returned values: the reset frequencies, the voltage constant, write-then-read of an oscillator entry and the masked control read-back. The bench scenarios also cover each unsupported-field case and the fact that a failed command leaves the data register untouched.

// File: rtl/cfg_txn_pkg.sv
package cfg_txn_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int DEV_W    = 12;

    localparam logic [ADDR_W-1:0] OFF_DATA = 8'hA0;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'hA4;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'hA8;

    // launch bit and the two reserved site-adjacent bits never persist
    localparam logic [DATA_W-1:0] CTRL_KEEP_MASK = 32'h7FF3_FFFF;

    localparam logic [5:0] FN_FREQ    = 6'd1;
    localparam logic [5:0] FN_SUPPLY  = 6'd2;
    localparam logic [5:0] FN_VIDSEL  = 6'd7;
    localparam logic [5:0] FN_HALT    = 6'd8;
    localparam logic [5:0] FN_RESTART = 6'd9;
    localparam logic [5:0] FN_DISPMOD = 6'd11;

    localparam logic [1:0] SITE_MAIN  = 2'd0;
    localparam logic [1:0] SITE_CARD  = 2'd1;

    typedef struct packed {
        logic       launch;
        logic       is_write;
        logic [3:0] ctl_sel;
        logic [5:0] func;
        logic [1:0] resvd;
        logic [1:0] site;
        logic [3:0] pos;
        logic [DEV_W-1:0] dev;
    } cmd_t;

    typedef enum logic [2:0] {
        OP_BAD,
        OP_FREQ_RD,
        OP_FREQ_WR,
        OP_SUPPLY_RD,
        OP_NOP_OK,
        OP_HALT,
        OP_RESTART
    } op_e;

    function automatic logic [DATA_W-1:0] freq_reset_val(input int idx);
        if (idx == 0)      return 32'd50000000;
        else if (idx == 1) return 32'd23750000;
        else               return 32'd24000000;
    endfunction

endpackage

// File: rtl/cfg_decode.sv
module cfg_decode
    import cfg_txn_pkg::*;
#(
    parameter int NUM_OSC = 6,
    localparam int IDX_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1
) (
    input  cmd_t             cmd,
    output op_e              op,
    output logic [IDX_W-1:0] osc_idx
);

    logic gate_ok;
    logic main_dev0;

    assign gate_ok   = (cmd.ctl_sel == 4'd0) && (cmd.pos == 4'd0) &&
                       ((cmd.site == SITE_MAIN) || (cmd.site == SITE_CARD));
    assign main_dev0 = (cmd.site == SITE_MAIN) && (cmd.dev == '0);
    assign osc_idx   = cmd.dev[IDX_W-1:0];

    always_comb begin
        op = OP_BAD;
        if (gate_ok) begin
            unique case (cmd.func)
                FN_FREQ: begin
                    if (cmd.site == SITE_MAIN && cmd.dev < DEV_W'(NUM_OSC))
                        op = cmd.is_write ? OP_FREQ_WR : OP_FREQ_RD;
                end
                FN_SUPPLY: begin
                    if (main_dev0 && !cmd.is_write) op = OP_SUPPLY_RD;
                end
                FN_VIDSEL, FN_DISPMOD: begin
                    if (main_dev0 && cmd.is_write) op = OP_NOP_OK;
                end
                FN_HALT: begin
                    if (main_dev0 && cmd.is_write) op = OP_HALT;
                end
                FN_RESTART: begin
                    if (main_dev0 && cmd.is_write) op = OP_RESTART;
                end
                default: op = OP_BAD;
            endcase
        end
    end

endmodule

// File: rtl/cfg_osc_bank.sv
module cfg_osc_bank
    import cfg_txn_pkg::*;
#(
    parameter int NUM_OSC = 6,
    localparam int IDX_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] freq_q [NUM_OSC];

    for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
        always_ff @(posedge clk) begin
            if (rst)
                freq_q[g] <= freq_reset_val(g);
            else if (wr_en && idx == IDX_W'(g))
                freq_q[g] <= wdata;
        end

        AST_OSC_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && idx == IDX_W'(g)) |=> $stable(freq_q[g])); // R6
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_OSC; i++)
            if (idx == IDX_W'(i)) rdata = freq_q[i];
    end

endmodule

// File: rtl/cfg_txn_ctrl.sv
module cfg_txn_ctrl
    import cfg_txn_pkg::*;
#(
    parameter int          NUM_OSC    = 6,
    parameter logic [31:0] SUPPLY_UV  = 32'd3300000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        shutdown_req,
    output logic        reboot_req
);

    localparam int IDX_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1;

    logic [DATA_W-1:0] data_q;
    cmd_t              ctrl_q;
    logic [1:0]        stat_q;
    logic              pend_q;
    logic              halt_q;
    logic              restart_q;

    op_e               op;
    logic [IDX_W-1:0]  osc_idx;
    logic [DATA_W-1:0] osc_rd;
    logic              hit_data, hit_ctrl, hit_stat, launch;
    logic              rd_done;
    logic [DATA_W-1:0] rd_val;

    assign hit_data = bus_wr && (bus_addr == OFF_DATA);
    assign hit_ctrl = bus_wr && (bus_addr == OFF_CTRL);
    assign hit_stat = bus_wr && (bus_addr == OFF_STAT);
    assign launch   = hit_ctrl && bus_wdata[31];

    cfg_decode #(.NUM_OSC(NUM_OSC)) u_dec (
        .cmd     (ctrl_q),
        .op      (op),
        .osc_idx (osc_idx)
    );

    cfg_osc_bank #(.NUM_OSC(NUM_OSC)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_en (pend_q && op == OP_FREQ_WR),
        .idx   (osc_idx),
        .wdata (data_q),
        .rdata (osc_rd)
    );

    assign rd_done = pend_q && (op == OP_FREQ_RD || op == OP_SUPPLY_RD);
    assign rd_val  = (op == OP_FREQ_RD) ? osc_rd : SUPPLY_UV;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q    <= '0;
            ctrl_q    <= '0;
            stat_q    <= '0;
            pend_q    <= 1'b0;
            halt_q    <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            if (hit_ctrl) ctrl_q <= cmd_t'(bus_wdata & CTRL_KEEP_MASK);
            pend_q <= launch;

            if (pend_q)        stat_q <= {op == OP_BAD, 1'b1};
            else if (launch)   stat_q <= 2'b00;
            else if (hit_stat) stat_q <= bus_wdata[1:0];

            if (rd_done)       data_q <= rd_val;
            else if (hit_data) data_q <= bus_wdata;

            halt_q    <= pend_q && op == OP_HALT;
            restart_q <= pend_q && op == OP_RESTART;
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFF_DATA: bus_rdata = data_q;
            OFF_CTRL: bus_rdata = ctrl_q;
            OFF_STAT: bus_rdata = {30'd0, stat_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign shutdown_req = halt_q;
    assign reboot_req   = restart_q;

    AST_DONE_NEXT: assert property (@(posedge clk) disable iff (rst)
        pend_q |=> stat_q[0]); // R4
    AST_ERR_UNSUP: assert property (@(posedge clk) disable iff (rst)
        (pend_q && op == OP_BAD) |=> (stat_q == 2'b11)); // R3
    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (pend_q && op != OP_BAD) |=> (stat_q == 2'b01)); // R4
    AST_PULSE_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        (shutdown_req || reboot_req) |-> $past(pend_q)); // R8
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(shutdown_req && reboot_req)); // R8

endmodule

// File: tb/tb_cfg_txn_ctrl.sv
module tb_cfg_txn_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    localparam logic [7:0] A_DATA = 8'hA0;
    localparam logic [7:0] A_CTRL = 8'hA4;
    localparam logic [7:0] A_STAT = 8'hA8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        shutdown_req, reboot_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    string cur_req = "R2";

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_txn_ctrl dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .shutdown_req(shutdown_req), .reboot_req(reboot_req)
    );

    // behavioural reference model
    logic [31:0] m_data, m_ctrl;
    logic [1:0]  m_stat;
    logic [31:0] m_osc [6];
    bit          m_pend, m_shut, m_reb;
    int          f_sel, f_fn, f_site, f_pos, f_dev, f_w;
    bit          t_err, t_rd, t_shut, t_reb;
    logic [31:0] t_val;

    always @(posedge clk) begin
        if (rst) begin
            m_data = 0; m_ctrl = 0; m_stat = 0;
            m_pend = 0; m_shut = 0; m_reb = 0;
            m_osc[0] = 50000000; m_osc[1] = 23750000;
            for (int i = 2; i < 6; i++) m_osc[i] = 24000000;
        end else begin
            t_err = 0; t_rd = 0; t_shut = 0; t_reb = 0; t_val = 0;
            if (m_pend) begin
                f_sel  = int'((m_ctrl >> 26) & 15);
                f_fn   = int'((m_ctrl >> 20) & 63);
                f_site = int'((m_ctrl >> 16) & 3);
                f_pos  = int'((m_ctrl >> 12) & 15);
                f_dev  = int'(m_ctrl & 4095);
                f_w    = int'((m_ctrl >> 30) & 1);
                t_err  = 1;
                if (f_sel == 0 && f_pos == 0 && f_site <= 1) begin
                    if (f_fn == 1 && f_site == 0 && f_dev < 6) begin
                        t_err = 0;
                        if (f_w == 1) m_osc[f_dev] = m_data;
                        else begin t_rd = 1; t_val = m_osc[f_dev]; end
                    end else if (f_fn == 2 && f_w == 0 && f_site == 0 && f_dev == 0) begin
                        t_err = 0; t_rd = 1; t_val = 3300000;
                    end else if (f_w == 1 && f_site == 0 && f_dev == 0) begin
                        if (f_fn == 7 || f_fn == 11) t_err = 0;
                        else if (f_fn == 8) begin t_err = 0; t_shut = 1; end
                        else if (f_fn == 9) begin t_err = 0; t_reb = 1; end
                    end
                end
            end
            if (m_pend) m_stat = {t_err, 1'b1};
            else if (bus_wr && bus_addr == A_CTRL && bus_wdata[31]) m_stat = 0;
            else if (bus_wr && bus_addr == A_STAT) m_stat = bus_wdata[1:0];
            if (m_pend && t_rd) m_data = t_val;
            else if (bus_wr && bus_addr == A_DATA) m_data = bus_wdata;
            if (bus_wr && bus_addr == A_CTRL) m_ctrl = bus_wdata & 32'h7FF3_FFFF;
            m_pend = bus_wr && bus_addr == A_CTRL && bus_wdata[31];
            m_shut = t_shut;
            m_reb  = t_reb;
        end
    end

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        if (a == A_DATA) return m_data;
        if (a == A_CTRL) return m_ctrl;
        if (a == A_STAT) return {30'd0, m_stat};
        return 0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            chk(cur_req, bus_rdata, model_rd(bus_addr));
            chk(cur_req, {31'd0, shutdown_req}, {31'd0, m_shut});
            chk(cur_req, {31'd0, reboot_req}, {31'd0, m_reb});
        end
    end

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // launch and wait until the completion edge has passed
    task automatic run(input logic [31:0] cmd);
        bwrite(A_CTRL, cmd);
        @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #2;
        chk(req, bus_rdata, exp);
    endtask

    initial begin : wd
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        cur_req = "R4";
        rd_chk("R4", A_STAT, 0);
        rd_chk("R1", A_CTRL, 0);
        rd_chk("R2", A_DATA, 0);

        // R4 timing: status cleared at launch edge, done one edge later
        bwrite(A_STAT, 32'h3);
        @(negedge clk); bus_wr = 1; bus_addr = A_CTRL; bus_wdata = 32'h8010_0000;
        @(negedge clk); bus_wr = 0; bus_addr = A_STAT; #2; chk("R4", bus_rdata, 0);
        @(negedge clk); #2; chk("R4", bus_rdata, 1);
        cur_req = "R5";
        rd_chk("R5", A_DATA, 50000000);
        run(32'h8010_0001); rd_chk("R5", A_DATA, 23750000);
        run(32'h8010_0005); rd_chk("R5", A_DATA, 24000000);
        bwrite(A_DATA, 32'd12345678);
        run(32'hC010_0002); rd_chk("R5", A_STAT, 1);
        bwrite(A_DATA, 0);
        run(32'h8010_0002); rd_chk("R5", A_DATA, 12345678);

        cur_req = "R6";
        bwrite(A_DATA, 32'hDEAD_BEEF);
        run(32'h8010_0006); rd_chk("R6", A_STAT, 3); rd_chk("R6", A_DATA, 32'hDEAD_BEEF);
        run(32'hC010_0007); rd_chk("R6", A_STAT, 3);
        run(32'h8010_0005); rd_chk("R6", A_DATA, 24000000);

        cur_req = "R7";
        run(32'h8020_0000); rd_chk("R7", A_DATA, 3300000); rd_chk("R7", A_STAT, 1);
        bwrite(A_DATA, 32'h55);
        run(32'h8020_0001); rd_chk("R7", A_STAT, 3); rd_chk("R7", A_DATA, 32'h55);
        run(32'hC020_0000); rd_chk("R7", A_STAT, 3);

        cur_req = "R3";
        run(32'h8410_0000); rd_chk("R3", A_STAT, 3); rd_chk("R3", A_DATA, 32'h55);
        run(32'h8010_1000); rd_chk("R3", A_STAT, 3);
        run(32'h8012_0000); rd_chk("R3", A_STAT, 3);
        run(32'h8011_0000); rd_chk("R3", A_STAT, 3);
        run(32'h8030_0000); rd_chk("R3", A_STAT, 3);

        cur_req = "R11";
        bwrite(A_STAT, 32'h2);
        bwrite(A_CTRL, 32'h7FFF_FFFF);
        rd_chk("R1", A_CTRL, 32'h7FF3_FFFF);
        rd_chk("R11", A_STAT, 2);
        rd_chk("R11", A_DATA, 32'h55);
        cur_req = "R1";
        run(32'hFFFF_FFFF); rd_chk("R1", A_CTRL, 32'h7FF3_FFFF); rd_chk("R1", A_STAT, 3);

        cur_req = "R8";
        bwrite(A_CTRL, 32'hC080_0000);
        @(negedge clk); #2; chk("R8", {31'd0, shutdown_req}, 1); chk("R8", {31'd0, reboot_req}, 0);
        @(negedge clk); #2; chk("R8", {31'd0, shutdown_req}, 0);
        bwrite(A_CTRL, 32'hC090_0000);
        @(negedge clk); #2; chk("R8", {31'd0, reboot_req}, 1); chk("R8", {31'd0, shutdown_req}, 0);
        @(negedge clk); #2; chk("R8", {31'd0, reboot_req}, 0);
        bwrite(A_CTRL, 32'h8080_0000);
        @(negedge clk); #2; chk("R8", {31'd0, shutdown_req}, 0);
        rd_chk("R8", A_STAT, 3);

        cur_req = "R9";
        run(32'hC070_0000); rd_chk("R9", A_STAT, 1); rd_chk("R9", A_DATA, 32'h55);
        run(32'hC0B0_0000); rd_chk("R9", A_STAT, 1);
        run(32'h80B0_0000); rd_chk("R9", A_STAT, 3);

        cur_req = "R10";
        bwrite(A_STAT, 32'hFFFF_FFFE); rd_chk("R10", A_STAT, 2);
        bwrite(A_STAT, 32'h0000_0004); rd_chk("R10", A_STAT, 0);

        cur_req = "R2";
        bwrite(8'h10, 32'hFFFF_FFFF); rd_chk("R2", 8'h10, 0);
        rd_chk("R2", A_DATA, 32'h55);
        bwrite(A_DATA, 32'h0BAD_F00D); rd_chk("R2", A_DATA, 32'h0BAD_F00D);

        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule